// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Interval and Periodic Tick Interrupts

This block keeps a 16-bit count of elapsed microseconds. A prescaler divides the system clock down to one enable pulse per microsecond, and the count advances on each pulse. The count never stops and wraps from its top value back to zero. Software takes time stamps by reading the count over an 8-bit register bus. The elapsed time between two events is the difference of two such reads, taken modulo 2^16.

The same microsecond enable drives two interrupt sources. The first is an interval interrupt. It comes from a down-counter that reloads itself from a 16-bit reload register, so the interrupt period can be set to the microsecond. The second is a fixed periodic tick, raised each time the low ten bits of the free-running count roll over, which is once every 1024 µs. Each source has a status flag and an enable bit. A flag sets whether or not its source is enabled, so software can poll the flags instead of taking the interrupts. Writing one to a flag bit clears that flag.

Register addresses: 0 reads the count's low byte, 1 reads the high-byte shadow, 2 is the reload low byte, 3 is the reload high byte, 4 holds the enables, and 5 holds the flags. In registers 4 and 5, bit 0 belongs to the interval source and bit 1 to the tick source.

Top module: `usTimer`

## Requirements
- R1: The count rises by exactly one once every CLK_PER_US clock cycles. It holds its value in all other cycles.
- R2: When a microsecond step occurs at count 0xFFFF, the count becomes 0x0000 and keeps running.
- R3: The tick flag (address 5, bit 1) sets on the microsecond step where count bits [9:0] move from 0x3FF to 0x000. It therefore sets once every 1024 µs.
- R4: On each microsecond step where the interval down-counter is zero, the interval flag (address 5, bit 0) sets and the down-counter reloads from the reload register. On other steps the down-counter decrements. With reload value N, the interval flag sets every N+1 µs.
- R5: A write to the reload high byte (address 3) loads the down-counter at once with the new 16-bit reload value. This write replaces that cycle's decrement or reload, and it raises no flag in that cycle.
- R6: A flag sets whether or not its source is enabled. intervalIrq equals the interval flag AND enable bit 0 of address 4. tickIrq equals the tick flag AND enable bit 1 of address 4.
- R7: Writing a one to a bit of address 5 clears that flag, and writing a zero leaves it unchanged. If a flag sets in the same cycle as it is cleared, the set takes effect.
- R8: A read of address 0 returns the live low byte of the count. The same read copies the high byte of the count, as it stood in that cycle, into a shadow register. Address 1 returns that shadow, so that the two bytes form one coherent 16-bit value.
- R9: After reset the count, shadow, enables and flags are zero, and the reload register and the down-counter are 0xFFFF.
- R10: Addresses 2, 3 and 4 read back what was last written to them. busRdata is zero whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of the read |
| intervalIrq | output | 1 | Interval interrupt request |
| tickIrq | output | 1 | 1.024 ms tick interrupt request |

## Verification
The bench steps the count through 0xFFFF. A design that saturates there, or that drops one microsecond at the wrap, makes the low-byte and shadow reads disagree with the reference model. It sets a reload of zero and then writes clear commands while the flag is being set. A design that lets the clear win loses an interval event, and the flag reads back as zero. It reads the two count bytes in separate accesses. A design without the shadow latch returns a high byte that has advanced since the low byte was read. It also turns one enable off while the matching flag keeps setting. Gating the flag instead of the output would hide the event from polling software.

// File: rtl/usTimerPkg.sv
package usTimerPkg;
  localparam int TMR_W   = 16;
  localparam int HALF_W  = TMR_W / 2;
  localparam int ADDR_W  = 3;
  localparam int INT_BIT  = 0;
  localparam int TICK_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_REL_LO = 3'd2,
    A_REL_HI = 3'd3,
    A_ENABLE = 3'd4,
    A_FLAGS  = 3'd5
  } regAddr_e;

  // strobes and values from control to datapath
  typedef struct packed {
    logic              latchHi;
    logic              restart;
    logic [TMR_W-1:0]  restartVal;
    logic [TMR_W-1:0]  reloadVal;
  } pathCmd_t;
endpackage

// File: rtl/usTimerPath.sv
module usTimerPath
  import usTimerPkg::*;
#(
  parameter int CLK_PER_US = 12,
  parameter int TICK_BITS  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCmd_t          cmd,
  output logic              usStrobe,
  output logic              tickEvt,
  output logic              intvEvt,
  output logic [TMR_W-1:0]  count,
  output logic [HALF_W-1:0] shadowHi
);
  logic [TMR_W-1:0] downCnt;

  generate
    if (CLK_PER_US <= 1) begin : g_noDiv
      assign usStrobe = 1'b1;
    end else begin : g_div
      localparam int PRE_W = $clog2(CLK_PER_US);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                 preCnt <= '0;
        else if (preCnt == PRE_LAST) preCnt <= '0;
        else                       preCnt <= preCnt + 1'b1;
      end
      assign usStrobe = (preCnt == PRE_LAST);
    end
  endgenerate

  assign tickEvt = usStrobe && (&count[TICK_BITS-1:0]);
  assign intvEvt = usStrobe && !cmd.restart && (downCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)         count <= '0;
    else if (usStrobe) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                downCnt <= '1;
    else if (cmd.restart)     downCnt <= cmd.restartVal;
    else if (usStrobe) begin
      if (downCnt == '0)      downCnt <= cmd.reloadVal;
      else                    downCnt <= downCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            shadowHi <= '0;
    else if (cmd.latchHi) shadowHi <= count[TMR_W-1:HALF_W];
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !usStrobe |=> count == $past(count));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (usStrobe && count == '1) |=> count == '0);
  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    intvEvt |=> downCnt == $past(cmd.reloadVal));
  p_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> downCnt == $past(cmd.restartVal));
  p_shadow_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.latchHi |=> shadowHi == $past(count[TMR_W-1:HALF_W]));
endmodule

// File: rtl/usTimerCtrl.sv
module usTimerCtrl
  import usTimerPkg::*;
#(
  parameter int TICK_BITS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [HALF_W-1:0] busWdata,
  output logic [HALF_W-1:0] busRdata,
  input  logic [TMR_W-1:0]  count,
  input  logic [HALF_W-1:0] shadowHi,
  input  logic              tickEvt,
  input  logic              intvEvt,
  output pathCmd_t          cmd,
  output logic              intervalIrq,
  output logic              tickIrq
);
  regAddr_e          addrE;
  logic              wrEn, rdEn;
  logic [HALF_W-1:0] relLo, relHi;
  logic              intEn, tickEn, intFlag, tickFlag;
  logic              clrInt, clrTick;

  assign addrE = regAddr_e'(busAddr);
  assign wrEn  = busSel && busWr;
  assign rdEn  = busSel && !busWr;
  assign clrInt  = wrEn && (addrE == A_FLAGS) && busWdata[INT_BIT];
  assign clrTick = wrEn && (addrE == A_FLAGS) && busWdata[TICK_BIT];

  always_comb begin
    cmd.latchHi    = rdEn && (addrE == A_CNT_LO);
    cmd.restart    = wrEn && (addrE == A_REL_HI);
    cmd.restartVal = {busWdata, relLo};
    cmd.reloadVal  = {relHi, relLo};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relLo  <= '1;
      relHi  <= '1;
      intEn  <= 1'b0;
      tickEn <= 1'b0;
    end else if (wrEn) begin
      case (addrE)
        A_REL_LO: relLo <= busWdata;
        A_REL_HI: relHi <= busWdata;
        A_ENABLE: begin
          intEn  <= busWdata[INT_BIT];
          tickEn <= busWdata[TICK_BIT];
        end
        default: ;
      endcase
    end
  end

  // set has priority over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intFlag  <= 1'b0;
      tickFlag <= 1'b0;
    end else begin
      intFlag  <= intvEvt || (intFlag && !clrInt);
      tickFlag <= tickEvt || (tickFlag && !clrTick);
    end
  end

  assign intervalIrq = intFlag && intEn;
  assign tickIrq     = tickFlag && tickEn;

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      case (addrE)
        A_CNT_LO: busRdata = count[HALF_W-1:0];
        A_CNT_HI: busRdata = shadowHi;
        A_REL_LO: busRdata = relLo;
        A_REL_HI: busRdata = relHi;
        A_ENABLE: begin
          busRdata[INT_BIT]  = intEn;
          busRdata[TICK_BIT] = tickEn;
        end
        A_FLAGS: begin
          busRdata[INT_BIT]  = intFlag;
          busRdata[TICK_BIT] = tickFlag;
        end
        default: ;
      endcase
    end
  end

  p_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tickFlag) |-> count[TICK_BITS-1:0] == '0);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    intvEvt |=> intFlag);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrTick && !tickEvt) |=> !tickFlag);
endmodule

// File: rtl/usTimer.sv
module usTimer
  import usTimerPkg::*;
#(
  parameter int CLK_PER_US = 12,
  parameter int TICK_BITS  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [HALF_W-1:0] busWdata,
  output logic [HALF_W-1:0] busRdata,
  output logic              intervalIrq,
  output logic              tickIrq
);
  pathCmd_t          cmd;
  logic              usStrobe, tickEvt, intvEvt;
  logic [TMR_W-1:0]  count;
  logic [HALF_W-1:0] shadowHi;

  usTimerPath #(.CLK_PER_US(CLK_PER_US), .TICK_BITS(TICK_BITS)) i_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .usStrobe(usStrobe),
    .tickEvt(tickEvt), .intvEvt(intvEvt), .count(count), .shadowHi(shadowHi));

  usTimerCtrl #(.TICK_BITS(TICK_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .count(count), .shadowHi(shadowHi), .tickEvt(tickEvt),
    .intvEvt(intvEvt), .cmd(cmd), .intervalIrq(intervalIrq),
    .tickIrq(tickIrq));

  p_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    usStrobe |=> count == $past(count) + 1'b1);
endmodule

// File: tb/test_usTimer.sv
module test_usTimer;
  localparam int P = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       intervalIrq, tickIrq;

  int errors = 0, checks = 0, cycles = 0;

  usTimer #(.CLK_PER_US(P)) i_usTimer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .intervalIrq(intervalIrq), .tickIrq(tickIrq));

  always #2 clk = ~clk;

  // behavioural reference model
  int mPre, mCnt, mDown, mRel, mShadow;
  bit mIntEn, mTickEn, mIntF, mTickF, stb, setI, setT;

  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mCnt = 0; mDown = 65535; mRel = 65535; mShadow = 0;
      mIntEn = 0; mTickEn = 0; mIntF = 0; mTickF = 0;
    end else begin
      stb  = (mPre == P - 1);
      mPre = stb ? 0 : mPre + 1;
      setT = stb && (mCnt % 1024 == 1023);
      setI = 0;
      if (busSel && busWr && busAddr == 3) mDown = busWdata * 256 + mRel % 256;
      else if (stb) begin
        if (mDown == 0) begin setI = 1; mDown = mRel; end
        else mDown = mDown - 1;
      end
      if (busSel && !busWr && busAddr == 0) mShadow = mCnt / 256;
      if (stb) mCnt = (mCnt + 1) % 65536;
      if (busSel && busWr) begin
        case (busAddr)
          3'd2: mRel = (mRel / 256) * 256 + busWdata;
          3'd3: mRel = busWdata * 256 + mRel % 256;
          3'd4: begin mIntEn = busWdata[0]; mTickEn = busWdata[1]; end
          3'd5: begin
            if (busWdata[0]) mIntF = 0;
            if (busWdata[1]) mTickF = 0;
          end
          default: ;
        endcase
      end
      if (setI) mIntF = 1;
      if (setT) mTickF = 1;
    end
  end

  function automatic int modelRd();
    if (!(busSel && !busWr)) return 0;
    case (busAddr)
      3'd0: return mCnt % 256;
      3'd1: return mShadow;
      3'd2: return mRel % 256;
      3'd3: return mRel / 256;
      3'd4: return {mTickEn, mIntEn};
      3'd5: return {mTickF, mIntF};
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // per-clock comparison away from the active edge, plus watchdog
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("R6 intervalIrq", intervalIrq, mIntEn && mIntF);
      check("R6 tickIrq", tickIrq, mTickEn && mTickF);
      check("R1 R8 R10 busRdata", busRdata, modelRd());
    end
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    busSel = 1; busWr = 1; busAddr = 3'(a); busWdata = 8'(d);
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(posedge clk); #1;
    busSel = 1; busWr = 0; busAddr = 3'(a);
    @(negedge clk); d = busRdata;
    @(posedge clk); #1;
    busSel = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    int d, lo, hi, prev;
    idle(3);
    #1 rstN = 1;
    // R9 reset state
    rd(3, d); check("R9 reload hi after reset", d, 8'hFF);
    rd(2, d); check("R9 reload lo after reset", d, 8'hFF);
    rd(4, d); check("R9 enables after reset", d, 0);
    rd(5, d); check("R9 flags after reset", d, 0);
    // R10 R5: program interval of 10 us, enable both sources
    wr(4, 3);
    rd(4, d); check("R10 enable readback", d, 3);
    wr(2, 9);
    wr(3, 0);
    rd(3, d); check("R10 reload hi readback", d, 0);
    idle(30);
    // R4 interval fired
    rd(5, d); check("R4 interval flag set", d & 1, 1);
    check("R6 intervalIrq with enable", intervalIrq, 1);
    // R7 set wins over clear with reload 0
    wr(2, 0); wr(3, 0);
    for (int i = 0; i < 4; i++) wr(5, 1);
    rd(5, d); check("R7 flag after clears at 1us period", d & 1, mIntF);
    // R6 disable interval enable: flag still sets, irq low
    wr(4, 2);
    wr(2, 4); wr(3, 0);
    wr(5, 1);
    idle(15);
    rd(5, d); check("R6 flag sets while disabled", d & 1, 1);
    check("R6 intervalIrq gated", intervalIrq, 0);
    // R3 tick flag after rollover
    wr(5, 2);
    while (mCnt % 1024 != 1) @(posedge clk);
    @(negedge clk);
    check("R3 tick flag after 0x3FF rollover", tickIrq, 1);
    // R8 coherent read
    rd(0, lo); rd(1, hi);
    check("R8 shadow matches latched high", hi, mShadow);
    // R2 wrap
    while (mCnt < 65530) @(posedge clk);
    rd(0, lo); rd(1, hi);
    prev = hi * 256 + lo;
    check("R2 near top", (prev >= 65530) ? 1 : 0, 1);
    idle(30);
    rd(0, lo); rd(1, hi);
    check("R2 wrapped to low value", hi * 256 + lo, mShadow * 256 + lo);
    check("R2 count after wrap small", (hi == 0 && lo < 40) ? 1 : 0, 1);
    idle(5);
    finishRun();
  end
endmodule